// File: doc/BRIEF.md
# Split-Bank Memory Bus Sequencer

This block sits on the memory-bus side of a secondary cache whose data array is 128 bits wide and connects it to a 64-bit clocked memory bus. The array is treated as two 64-bit banks. The low bank holds data bits [63:0] and the high bank holds bits [127:64]. Each bank has its own active-low output enable and its own active-low ready strobe. A line transfer is cut into 64-bit beats that alternate between the banks, always starting with the low bank. The sequencer counts these beats.

On a linefill (read), each valid bus beat is captured by a one-clock ready strobe to the bank whose turn it is. On a write-back, the output enables take turns. An idle clock sits between them, so the two banks never drive the bus together. The block also holds off the CPU-side burst ready until two memory-side ready strobes have gone out. A one-clock done pulse closes each transfer.

Top module: `splitbank_seq`

## Requirements
- R1: `long_line_i` is sampled with the start pulse: 0 selects a 64-byte line of 8 bus beats, 1 selects a 128-byte line of 16 bus beats.
- R2: Beat n of a transfer (counting from 0) belongs to the low bank when n is even and to the high bank when n is odd.
- R3: During a read (`dir_i`=0 at start), a clock edge that samples `beat_vld_i` high makes the current bank's ready strobe low for exactly the following clock. The two ready strobes are never low together.
- R4: During a write-back (`dir_i`=1 at start), the current bank's output enable is low from the clock after the start edge, or after the gap, until the edge that samples `beat_ack_i` high. The two output enables are never low together.
- R5: After each write beat is acknowledged, both output enables are high for exactly one clock. Then the next bank's enable goes low. The enable for the final beat is followed only by idle.
- R6: `cpu_brdy_n_o` is low only during a read. It is low from the clock after the second ready strobe through the clock of the final ready strobe. It stays high for the whole of a write-back.
- R7: `done_o` is high for exactly one clock. That clock is the second one after the edge that samples the final beat (`beat_vld_i` for a read, `beat_ack_i` for a write). From then on all four bank strobes stay high until a new start.
- R8: A start pulse that arrives while a transfer is in progress is ignored, including its `dir_i` and `long_line_i` values.
- R9: A synchronous active-high reset returns the block to idle and clears the beat count. It sets all five active-low outputs high and `done_o` low.
- R10: `beat_ack_i` has no effect during a read, and `beat_vld_i` has no effect during a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a line transfer (taken only when idle) |
| dir_i | input | 1 | Transfer direction at start: 0 read/linefill, 1 write-back |
| long_line_i | input | 1 | Line size at start: 0 = 8 beats, 1 = 16 beats |
| beat_vld_i | input | 1 | Read beat present on the 64-bit bus |
| beat_ack_i | input | 1 | Bus accepted the write beat being driven |
| oel_n_o | output | 1 | Low-bank output enable, active low |
| oeh_n_o | output | 1 | High-bank output enable, active low |
| rdyl_n_o | output | 1 | Low-bank ready strobe, active low |
| rdyh_n_o | output | 1 | High-bank ready strobe, active low |
| cpu_brdy_n_o | output | 1 | CPU-side burst ready permission, active low |
| done_o | output | 1 | One-clock end-of-transfer pulse |

## Verification
The bench mixes random transfers of both directions and both line sizes, with `beat_vld_i` and `beat_ack_i` toggled at random. This separates stall handling from the beat count, and shows that the unused handshake in each direction has no effect. Back-to-back valid beats on 8- and 16-beat reads test strobe alternation and the two-strobe hold-off of the CPU ready when there are no gaps. Write-backs with immediate acknowledges test that the one-clock bank-switch gap is present even at the fastest rate. Start pulses with the opposite direction, sent into a busy transfer, show whether a request that should be ignored corrupts the latched mode.

// File: rtl/splitbank_pkg.sv
package splitbank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WDRV,
        ST_WGAP,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    wr;
        logic    long_ln;
        logic    oel_n;
        logic    oeh_n;
        logic    rdyl_n;
        logic    rdyh_n;
        logic    done;
    } seq_regs_t;

endpackage

// File: rtl/sb_beat_ctr.sv
module sb_beat_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt_q,
    output logic             bank_o
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (adv)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // even beat -> low bank, odd beat -> high bank
    assign bank_o = cnt_q[0];

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (cnt_q[0] != $past(cnt_q[0]))); // R2

endmodule

// File: rtl/sb_cpu_gate.sv
module sb_cpu_gate #(
    parameter int CNT_W      = 5,
    parameter int GATE_BEATS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] cnt,
    output logic             brdy_n_q
);

    localparam logic [CNT_W-1:0] GATE_CNT = CNT_W'(GATE_BEATS);

    logic brdy_n_d;

    always_comb begin
        brdy_n_d = !(rd_en && (cnt >= GATE_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst)
            brdy_n_q <= 1'b1;
        else
            brdy_n_q <= brdy_n_d;
    end

endmodule

// File: rtl/splitbank_seq.sv
module splitbank_seq
    import splitbank_pkg::*;
#(
    parameter int BEATS_SHORT    = 8,
    parameter int BEATS_LONG     = 16,
    parameter int CPU_GATE_BEATS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic dir_i,
    input  logic long_line_i,
    input  logic beat_vld_i,
    input  logic beat_ack_i,
    output logic oel_n_o,
    output logic oeh_n_o,
    output logic rdyl_n_o,
    output logic rdyh_n_o,
    output logic cpu_brdy_n_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(BEATS_LONG + 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(BEATS_SHORT - 1);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(BEATS_LONG - 1);
    localparam logic [CNT_W-1:0] GATE_CNT = CNT_W'(CPU_GATE_BEATS);

    seq_regs_t        seq_d, seq_q;
    logic             ctr_clr, ctr_adv;
    logic [CNT_W-1:0] cnt_q;
    logic             bank;
    logic             is_last;

    sb_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctr_clr),
        .adv    (ctr_adv),
        .cnt_q  (cnt_q),
        .bank_o (bank)
    );

    sb_cpu_gate #(.CNT_W(CNT_W), .GATE_BEATS(CPU_GATE_BEATS)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (seq_q.st == ST_RD),
        .cnt      (cnt_q),
        .brdy_n_q (cpu_brdy_n_o)
    );

    assign is_last = (cnt_q == (seq_q.long_ln ? LAST_L : LAST_S));

    always_comb begin
        seq_d        = seq_q;
        seq_d.oel_n  = 1'b1;
        seq_d.oeh_n  = 1'b1;
        seq_d.rdyl_n = 1'b1;
        seq_d.rdyh_n = 1'b1;
        seq_d.done   = 1'b0;
        ctr_clr      = 1'b0;
        ctr_adv      = 1'b0;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctr_clr       = 1'b1;
                    seq_d.wr      = dir_i;
                    seq_d.long_ln = long_line_i;
                    if (dir_i) begin
                        seq_d.st    = ST_WDRV;
                        seq_d.oel_n = 1'b0;
                    end else begin
                        seq_d.st = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (beat_vld_i) begin
                    ctr_adv = 1'b1;
                    if (bank) seq_d.rdyh_n = 1'b0;
                    else      seq_d.rdyl_n = 1'b0;
                    if (is_last) seq_d.st = ST_FIN;
                end
            end
            ST_WDRV: begin
                if (beat_ack_i) begin
                    ctr_adv  = 1'b1;
                    seq_d.st = is_last ? ST_FIN : ST_WGAP;
                end else begin
                    if (bank) seq_d.oeh_n = 1'b0;
                    else      seq_d.oel_n = 1'b0;
                end
            end
            ST_WGAP: begin
                seq_d.st = ST_WDRV;
                if (bank) seq_d.oeh_n = 1'b0;
                else      seq_d.oel_n = 1'b0;
            end
            ST_FIN: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st      <= ST_IDLE;
            seq_q.wr      <= 1'b0;
            seq_q.long_ln <= 1'b0;
            seq_q.oel_n   <= 1'b1;
            seq_q.oeh_n   <= 1'b1;
            seq_q.rdyl_n  <= 1'b1;
            seq_q.rdyh_n  <= 1'b1;
            seq_q.done    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign oel_n_o  = seq_q.oel_n;
    assign oeh_n_o  = seq_q.oeh_n;
    assign rdyl_n_o = seq_q.rdyl_n;
    assign rdyh_n_o = seq_q.rdyh_n;
    assign done_o   = seq_q.done;

    AST_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!oel_n_o && !oeh_n_o)); // R4
    AST_RDY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rdyl_n_o && !rdyh_n_o)); // R3
    AST_RDYL_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !rdyl_n_o |=> rdyl_n_o); // R3
    AST_RDYH_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        !rdyh_n_o |=> rdyh_n_o); // R3
    AST_OEL_GAP: assert property (@(posedge clk) disable iff (rst)
        !oel_n_o |=> oeh_n_o); // R5
    AST_OEH_GAP: assert property (@(posedge clk) disable iff (rst)
        !oeh_n_o |=> oel_n_o); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_IDLE) |-> (oel_n_o && oeh_n_o && rdyl_n_o && rdyh_n_o)); // R7
    AST_CPU_GATE: assert property (@(posedge clk) disable iff (rst)
        !cpu_brdy_n_o |-> (!seq_q.wr && cnt_q >= GATE_CNT)); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st != ST_IDLE && seq_q.st != ST_FIN && start_i)
            |=> ($stable(seq_q.wr) && $stable(seq_q.long_ln))); // R8

endmodule

// File: tb/splitbank_seq_bench.sv
module splitbank_seq_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, dir_i = 1'b0, long_line_i = 1'b0;
    logic beat_vld_i = 1'b0, beat_ack_i = 1'b0;
    logic oel_n_o, oeh_n_o, rdyl_n_o, rdyh_n_o, cpu_brdy_n_o, done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    splitbank_seq u_splitbank_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .dir_i        (dir_i),
        .long_line_i  (long_line_i),
        .beat_vld_i   (beat_vld_i),
        .beat_ack_i   (beat_ack_i),
        .oel_n_o      (oel_n_o),
        .oeh_n_o      (oeh_n_o),
        .rdyl_n_o     (rdyl_n_o),
        .rdyh_n_o     (rdyh_n_o),
        .cpu_brdy_n_o (cpu_brdy_n_o),
        .done_o       (done_o)
    );

    // reference model: 0 idle, 1 read, 2 write drive, 3 write gap, 4 finish
    int   m_st = 0, m_len = 8, m_cnt = 0, m_strobes = 0;
    logic m_wr = 1'b0;
    logic e_oel = 1, e_oeh = 1, e_rl = 1, e_rh = 1, e_cpu = 1, e_done = 0;

    function automatic int beats_for(input logic long_sel); // R1
        return long_sel ? 16 : 8;
    endfunction

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_strobes = 0; m_wr = 0;
        e_oel = 1; e_oeh = 1; e_rl = 1; e_rh = 1; e_cpu = 1; e_done = 0;
    endtask

    task automatic model_step(input logic s, d, l, v, a);
        int old_st  = m_st;
        int old_cnt = m_cnt;
        e_oel = 1; e_oeh = 1; e_rl = 1; e_rh = 1; e_done = 0;
        case (old_st)
            0: if (s) begin
                   m_wr = d; m_len = beats_for(l); m_cnt = 0; m_strobes = 0;
                   m_st = d ? 2 : 1;
                   if (d) e_oel = 0;
               end
            1: if (v) begin
                   if (m_cnt % 2 == 0) e_rl = 0; else e_rh = 0;   // R2
                   m_cnt++; m_strobes++;
                   if (m_cnt == m_len) m_st = 4;
               end
            2: if (a) begin
                   m_cnt++;
                   m_st = (m_cnt == m_len) ? 4 : 3;
               end else begin
                   if (m_cnt % 2 == 0) e_oel = 0; else e_oeh = 0;
               end
            3: begin
                   m_st = 2;
                   if (m_cnt % 2 == 0) e_oel = 0; else e_oeh = 0;
               end
            default: begin m_st = 0; e_done = 1; end
        endcase
        e_cpu = !(old_st == 1 && old_cnt >= 2);
    endtask

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag == "" ? "R3" : tag, "rdyl_n_o", rdyl_n_o, e_rl);
        chk(tag == "" ? "R3" : tag, "rdyh_n_o", rdyh_n_o, e_rh);
        chk(tag == "" ? "R4" : tag, "oel_n_o", oel_n_o, e_oel);
        chk(tag == "" ? "R5" : tag, "oeh_n_o", oeh_n_o, e_oeh);
        chk(tag == "" ? "R6" : tag, "cpu_brdy_n_o", cpu_brdy_n_o, e_cpu);
        chk(tag == "" ? "R7" : tag, "done_o", done_o, e_done);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic s, d, l, v, a, input string tag);
        start_i = s; dir_i = d; long_line_i = l; beat_vld_i = v; beat_ack_i = a;
        @(posedge clk);
        model_step(s, d, l, v, a);
        @(negedge clk);
        check_all(tag);
        if (e_done && !m_wr) begin
            checks++;   // R1: strobes issued per read equal the selected beat count
            if (m_strobes != m_len) begin
                errors++;
                $display("FAIL R1 strobe count actual=%0d expected=%0d", m_strobes, m_len);
            end
        end
    endtask

    task automatic run_read(input logic l, input string tag);
        cyc(1, 0, l, 0, 0, tag);
        for (int i = 0; i < beats_for(l); i++) cyc(0, 0, 0, 1, 1, tag);
        cyc(0, 0, 0, 0, 0, tag);
        cyc(0, 0, 0, 0, 0, tag);
    endtask

    task automatic run_write(input logic l, input string tag);
        cyc(1, 1, l, 0, 0, tag);
        while (m_st != 0) cyc(0, 0, 0, 1, 1, tag);
        cyc(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5B1D));
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        check_all("R9");
        rst = 1'b0;

        run_read(1'b0, "R2");   // 8 back-to-back beats
        run_read(1'b1, "R1");   // 16 back-to-back beats
        run_write(1'b0, "R5");  // immediate acks, gap every switch
        run_write(1'b1, "R4");

        // busy start with opposite direction and size must be ignored
        cyc(1, 0, 0, 0, 0, "R8");
        cyc(1, 1, 1, 1, 0, "R8");
        cyc(1, 1, 1, 0, 1, "R10");
        while (m_st != 0) cyc(1, 1, 1, 1, 1, "R8");
        cyc(0, 0, 0, 0, 0, "R8");

        // write with vld toggled but no ack: no progress
        cyc(1, 1, 0, 0, 0, "R10");
        repeat (4) cyc(0, 0, 0, 1, 0, "R10");
        while (m_st != 0) cyc(0, 0, 0, 0, 1, "R10");

        // random traffic
        for (int n = 0; n < 6000; n++) begin
            cyc(($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                ($urandom % 10) < 7, ($urandom % 2), "");
        end

        // reset mid-transfer
        run_read(1'b1, "R6");
        cyc(1, 0, 1, 1, 0, "R9");
        cyc(0, 0, 0, 1, 0, "R9");
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        check_all("R9");
        rst = 1'b0;
        run_read(1'b0, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule